// File: doc/BRIEF.md
# Dual-Protocol Host Bus Slave Interface

This block is the host-side front end of a peripheral controller. A host reaches a bank-switched register window and a 32-bit packet data port through it. Two bus protocols share a single address decoder. The first is a strobe-timed asynchronous bus, where the read and write strobes carry the timing and a ready output stretches slow cycles. The second is a clocked local bus, where the address strobe and a cycle signal start a transfer on a clock edge and a registered ready output ends it. The two protocols may take turns on the bus but never run at the same time. In this model the host clock and the internal clock are the same signal.

The address passes through while the address strobe is low and both data strobes are idle. When the address strobe rises the address is held. A separate chip select for direct memory access skips address decode and bank selection and goes straight to the packet port, one full 32-bit word per access. A strap input selects a 16-bit host. In that mode only the low data lanes are used, and address bit 1 decides which half of the internal word those lanes reach. The register contents and the packet memory are simple behavioural stand-ins.

Top module: `hostBusUnit`

## Requirements
- R1: An access is selected only when `addrIn[15:4]` equals `BASE_ADDR` and `addrEnN` is low, or when `dataCsN` is low. A write that is not selected changes no register, no bank and no packet word.
- R2: The address passes through while `addrStrobeN` is low with `rdN` and `wrN` both high. It is held once `addrStrobeN` rises, so later changes on `addrIn` during the data phase have no effect.
- R3: Each active-low `byteEnN[i]` enables lane `wrData[8i+7:8i]`. Byte, half-word and full-word writes update only the enabled bytes of a register or of the packet word.
- R4: A write with all four lanes enabled at offset 0xC on a 32-bit host loads only the bank select field from `wrData[16+BANK_W-1:16]`. The low half-word register at 0xC/0xD keeps its value.
- R5: Offset 0xE holds the bank select. Its low `BANK_W` bits pick one of `2**BANK_W` banks of four 32-bit registers. Reading offset 0xC in any bank returns the bank select in bits 31:16 and that bank's own half-word in bits 15:0.
- R6: When `bus16` is high and `dataCsN` is high, only `byteEnN[1:0]` and lanes 15:0 are used. Address bit 1 set maps the lanes to internal bits 31:16; address bit 1 clear maps them to bits 15:0. Reads return the chosen half on bits 15:0 and zero on bits 31:16.
- R7: On the asynchronous bus, a write is committed in the clock cycle where `wrN` returns high. A read that targets the packet port drives `asyncReady` low in the cycle of the `rdN` falling edge and in the cycle after it, then drives it high. Register reads keep `asyncReady` high.
- R8: A clocked cycle starts on an edge where `addrStrobeN` and `cycleN` are low, `rdN` and `wrN` are high, and the access is selected. `writeNotRead` high means write, and the write is committed at that edge. `syncReadyN` is low for exactly the one following cycle. An unselected clocked cycle leaves `syncReadyN` high.
- R9: The packet port is offset 0x8 of bank `DATA_BANK`, or any access with `dataCsN` low. Each access that includes the top byte lane moves the packet pointer forward one word, and the pointer wraps after `DEPTH` words.
- R10: After reset all registers and packet words are zero, the bank is 0, `asyncReady` is high and `syncReadyN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, also used as host clock for clocked cycles |
| rstN | input | 1 | Active-low synchronous reset |
| addrIn | input | 16 | Host address |
| addrStrobeN | input | 1 | Address strobe, active low, address held on its rise |
| addrEnN | input | 1 | Address enable, active low |
| rdN | input | 1 | Asynchronous read strobe, active low |
| wrN | input | 1 | Asynchronous write strobe, active low |
| byteEnN | input | 4 | Byte lane enables, active low |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data |
| asyncReady | output | 1 | Wait-extension ready for asynchronous cycles |
| cycleN | input | 1 | Clocked-bus cycle request, active low |
| writeNotRead | input | 1 | Clocked-bus direction, high for write |
| syncReadyN | output | 1 | Clocked-bus completion, active low |
| dataCsN | input | 1 | Direct packet-port chip select, active low |
| bus16 | input | 1 | High for a 16-bit host |

## Verification
The bench uses `BASE_ADDR` 0x030, `BANK_W` 3, `DEPTH` 16, `WAIT_CYC` 2 and `DATA_BANK` 2. With a 16-word packet memory, a burst of sixteen chip-select writes followed by sixteen reads wraps the pointer within a short run, and one further read shows that it wrapped to word 0. With three bank bits, the bench can move between banks 0, 2 and 3 and show that registers in different banks stay separate while the bank select reads the same from each. A wait of two cycles makes the ready stretch visible at the leading edge and in the cycle after it.

// File: rtl/hbuPkg.sv
package hbuPkg;
  typedef struct packed {
    logic writeStb;
    logic readDone;
  } hbuStrobeT;
endpackage

// File: rtl/hbuDecode.sv
module hbuDecode #(
  parameter logic [11:0] BASE_ADDR = 12'h030,
  parameter int BANK_W = 3,
  parameter int DATA_BANK = 2,
  parameter int DATA_WORD = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       addrIn,
  input  logic              addrStrobeN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              addrEnN,
  input  logic              dataCsN,
  input  logic [3:0]        byteEnN,
  input  logic              bus16,
  input  logic [BANK_W-1:0] bankSel,
  output logic              sel,
  output logic              dataTgt,
  output logic [1:0]        wordIdx,
  output logic              highHalf,
  output logic [3:0]        laneEn,
  output logic              fullWord,
  output logic              narrow
);
  logic [15:1] addrQ;
  logic [15:1] effAddr;
  logic passOpen, directCs, baseHit;
  logic unusedBits;

  assign passOpen = !addrStrobeN && rdN && wrN;
  assign effAddr  = passOpen ? addrIn[15:1] : addrQ;
  assign unusedBits = addrIn[0];

  always_ff @(posedge clk) begin
    if (!rstN) addrQ <= '0;
    else if (passOpen) addrQ <= addrIn[15:1];
  end

  assign directCs = !dataCsN;
  assign baseHit  = (effAddr[15:4] == BASE_ADDR) && !addrEnN;
  assign sel      = directCs || baseHit;
  assign wordIdx  = effAddr[3:2];
  assign highHalf = effAddr[1];
  assign dataTgt  = directCs ||
                    (baseHit && wordIdx == 2'(DATA_WORD) && bankSel == BANK_W'(DATA_BANK));
  assign narrow   = bus16 && !directCs;

  always_comb begin
    if (directCs)     laneEn = 4'hF;
    else if (narrow)  laneEn = highHalf ? {~byteEnN[1:0], 2'b00} : {2'b00, ~byteEnN[1:0]};
    else              laneEn = ~byteEnN;
  end

  assign fullWord = !narrow && (laneEn == 4'hF);
endmodule

// File: rtl/hbuCtrl.sv
module hbuCtrl
  import hbuPkg::*;
#(
  parameter int WAIT_CYC = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rdN,
  input  logic      wrN,
  input  logic      cycleN,
  input  logic      addrStrobeN,
  input  logic      writeNotRead,
  input  logic      sel,
  input  logic      dataTgt,
  output hbuStrobeT stb,
  output logic      asyncReady,
  output logic      syncReadyN
);
  localparam int CNT_W = $clog2(WAIT_CYC + 1);

  logic rdQ, wrQ;
  logic rdLead, rdTrail, wrTrail;
  logic syncStart, syncPend, pendRd;
  logic [CNT_W-1:0] waitCnt;

  assign rdLead    = rdQ && !rdN;
  assign rdTrail   = !rdQ && rdN;
  assign wrTrail   = !wrQ && wrN;
  assign syncStart = !addrStrobeN && !cycleN && rdN && wrN && sel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ      <= 1'b1;
      wrQ      <= 1'b1;
      syncPend <= 1'b0;
      pendRd   <= 1'b0;
      waitCnt  <= '0;
    end else begin
      rdQ      <= rdN;
      wrQ      <= wrN;
      syncPend <= syncStart;
      pendRd   <= syncStart && !writeNotRead;
      if (rdLead && dataTgt)  waitCnt <= CNT_W'(WAIT_CYC - 1);
      else if (waitCnt != 0)  waitCnt <= waitCnt - 1'b1;
    end
  end

  assign asyncReady   = !((rdLead && dataTgt) || (waitCnt != 0));
  assign syncReadyN   = !syncPend;
  assign stb.writeStb = (wrTrail && sel) || (syncStart && writeNotRead);
  assign stb.readDone = (rdTrail && sel) || (syncPend && pendRd);

  AST_WAIT_SECOND: assert property (@(posedge clk) disable iff (!rstN)
    (rdLead && dataTgt) |=> !asyncReady);  // R7
  AST_SYNC_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    syncStart |=> !syncReadyN);  // R8
  AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    !syncReadyN |=> syncReadyN);  // R8
  AST_MODES_APART: assert property (@(posedge clk) disable iff (!rstN)
    !cycleN |-> (rdN && wrN));  // R8
endmodule

// File: rtl/hbuDatapath.sv
module hbuDatapath
  import hbuPkg::*;
#(
  parameter int BANK_W = 3,
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  hbuStrobeT         stb,
  input  logic              sel,
  input  logic              dataTgt,
  input  logic [1:0]        wordIdx,
  input  logic              highHalf,
  input  logic [3:0]        laneEn,
  input  logic              fullWord,
  input  logic              narrow,
  input  logic [31:0]       wrData,
  output logic [BANK_W-1:0] bankSel,
  output logic [31:0]       rdData
);
  localparam int NUM_BANKS = 2 ** BANK_W;
  localparam int PTR_W = $clog2(DEPTH);

  logic [31:0] regs [NUM_BANKS][4];
  logic [31:0] pktMem [DEPTH];
  logic [PTR_W-1:0] ptr;
  logic [31:0] wrInt, word;
  logic [15:0] curLow, prevLow;
  logic [BANK_W-1:0] prevBank;

  assign wrInt  = narrow ? {2{wrData[15:0]}} : wrData;
  assign curLow = regs[bankSel][3][15:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankSel <= '0;
      ptr     <= '0;
      for (int i = 0; i < NUM_BANKS; i++)
        for (int j = 0; j < 4; j++) regs[i][j] <= '0;
      for (int k = 0; k < DEPTH; k++) pktMem[k] <= '0;
    end else if (stb.writeStb && sel) begin
      if (dataTgt) begin
        for (int b = 0; b < 4; b++)
          if (laneEn[b]) pktMem[ptr][8*b +: 8] <= wrInt[8*b +: 8];
        if (laneEn[3]) ptr <= ptr + 1'b1;
      end else if (wordIdx == 2'd3) begin
        if (laneEn[2]) bankSel <= wrInt[16 +: BANK_W];
        if (!fullWord)
          for (int b = 0; b < 2; b++)
            if (laneEn[b]) regs[bankSel][3][8*b +: 8] <= wrInt[8*b +: 8];
      end else begin
        for (int b = 0; b < 4; b++)
          if (laneEn[b]) regs[bankSel][wordIdx][8*b +: 8] <= wrInt[8*b +: 8];
      end
    end else if (stb.readDone && sel && dataTgt && laneEn[3]) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_comb begin
    if (dataTgt)              word = pktMem[ptr];
    else if (wordIdx == 2'd3) word = {{(16-BANK_W){1'b0}}, bankSel, curLow};
    else                      word = regs[bankSel][wordIdx];
  end

  assign rdData = narrow ? {16'h0, highHalf ? word[31:16] : word[15:0]} : word;

  always_ff @(posedge clk) begin
    prevBank <= bankSel;
    prevLow  <= curLow;
  end

  AST_MISS_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rstN)
    !sel |=> $stable(bankSel));  // R1
  AST_DWORD_LOW_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.writeStb && sel && !dataTgt && wordIdx == 2'd3 && fullWord)
      |=> (regs[prevBank][3][15:0] == prevLow));  // R4
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (ptr == $past(ptr) || ptr == $past(ptr) + 1'b1));  // R9
endmodule

// File: rtl/hostBusUnit.sv
module hostBusUnit
  import hbuPkg::*;
#(
  parameter logic [11:0] BASE_ADDR = 12'h030,
  parameter int BANK_W = 3,
  parameter int DEPTH = 16,
  parameter int WAIT_CYC = 2,
  parameter int DATA_BANK = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] addrIn,
  input  logic        addrStrobeN,
  input  logic        addrEnN,
  input  logic        rdN,
  input  logic        wrN,
  input  logic [3:0]  byteEnN,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        asyncReady,
  input  logic        cycleN,
  input  logic        writeNotRead,
  output logic        syncReadyN,
  input  logic        dataCsN,
  input  logic        bus16
);
  hbuStrobeT stb;
  logic sel, dataTgt, highHalf, fullWord, narrow;
  logic [1:0] wordIdx;
  logic [3:0] laneEn;
  logic [BANK_W-1:0] bankSel;

  hbuDecode #(.BASE_ADDR(BASE_ADDR), .BANK_W(BANK_W), .DATA_BANK(DATA_BANK), .DATA_WORD(2)) uDec (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .addrStrobeN(addrStrobeN), .rdN(rdN), .wrN(wrN),
    .addrEnN(addrEnN), .dataCsN(dataCsN), .byteEnN(byteEnN), .bus16(bus16), .bankSel(bankSel),
    .sel(sel), .dataTgt(dataTgt), .wordIdx(wordIdx), .highHalf(highHalf), .laneEn(laneEn),
    .fullWord(fullWord), .narrow(narrow));

  hbuCtrl #(.WAIT_CYC(WAIT_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .rdN(rdN), .wrN(wrN), .cycleN(cycleN), .addrStrobeN(addrStrobeN),
    .writeNotRead(writeNotRead), .sel(sel), .dataTgt(dataTgt), .stb(stb),
    .asyncReady(asyncReady), .syncReadyN(syncReadyN));

  hbuDatapath #(.BANK_W(BANK_W), .DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .sel(sel), .dataTgt(dataTgt), .wordIdx(wordIdx),
    .highHalf(highHalf), .laneEn(laneEn), .fullWord(fullWord), .narrow(narrow),
    .wrData(wrData), .bankSel(bankSel), .rdData(rdData));
endmodule

// File: tb/sim_hostBusUnit.sv
module sim_hostBusUnit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] addrIn = '0;
  logic addrStrobeN = 1'b1, addrEnN = 1'b0, rdN = 1'b1, wrN = 1'b1;
  logic [3:0] byteEnN = 4'h0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic asyncReady, syncReadyN;
  logic cycleN = 1'b1, writeNotRead = 1'b0, dataCsN = 1'b1, bus16 = 1'b0;

  int vectors = 0, fails = 0;
  logic [31:0] actQ[$], expQ[$];
  string tagQ[$];
  logic [31:0] expMem [16];
  logic [31:0] got;
  bit done = 0;

  always #2 clk = ~clk;

  hostBusUnit #(.BASE_ADDR(12'h030), .BANK_W(3), .DEPTH(16), .WAIT_CYC(2), .DATA_BANK(2)) u0 (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .addrStrobeN(addrStrobeN), .addrEnN(addrEnN),
    .rdN(rdN), .wrN(wrN), .byteEnN(byteEnN), .wrData(wrData), .rdData(rdData),
    .asyncReady(asyncReady), .cycleN(cycleN), .writeNotRead(writeNotRead),
    .syncReadyN(syncReadyN), .dataCsN(dataCsN), .bus16(bus16));

  task automatic push(input logic [31:0] act, input logic [31:0] exp, input string tag);
    actQ.push_back(act); expQ.push_back(exp); tagQ.push_back(tag);
  endtask

  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      logic [31:0] a, e;
      string t;
      a = actQ.pop_front(); e = expQ.pop_front(); t = tagQ.pop_front();
      vectors++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic asyncWrite(input logic [15:0] addr, input logic [3:0] be, input logic [31:0] data);
    step(); addrIn = addr; addrStrobeN = 1'b0;
    step(); addrStrobeN = 1'b1; addrIn = 16'hFFFF; wrData = data; byteEnN = be; wrN = 1'b0;
    step(); wrN = 1'b1;
    step();
  endtask

  task automatic asyncRead(input logic [15:0] addr, input logic [3:0] be, input bit isData,
                           input logic [31:0] exp, input string tag);
    step(); addrIn = addr; addrStrobeN = 1'b0;
    step(); addrStrobeN = 1'b1; addrIn = 16'hFFFF; byteEnN = be; rdN = 1'b0;
    @(negedge clk); push({31'b0, asyncReady}, isData ? 32'd0 : 32'd1, "R7 ready at leading edge");
    step(); @(negedge clk); push({31'b0, asyncReady}, isData ? 32'd0 : 32'd1, "R7 ready one cycle on");
    step(); @(negedge clk); push({31'b0, asyncReady}, 32'd1, "R7 ready returned");
    push(rdData, exp, tag);
    step(); rdN = 1'b1;
    step();
  endtask

  task automatic syncAccess(input logic [15:0] addr, input logic [3:0] be, input bit wnr,
                            input logic [31:0] data, input bit hitExp, input bit chkData,
                            input logic [31:0] exp, input string tag);
    step(); addrIn = addr; addrStrobeN = 1'b0; cycleN = 1'b0; writeNotRead = wnr;
    wrData = data; byteEnN = be;
    @(negedge clk); push({31'b0, syncReadyN}, 32'd1, "R8 ready idle at start");
    step(); addrStrobeN = 1'b1; cycleN = 1'b1; addrIn = 16'hFFFF;
    @(negedge clk); push({31'b0, syncReadyN}, hitExp ? 32'd0 : 32'd1, "R8 ready after start");
    if (chkData) push(rdData, exp, tag);
    step(); @(negedge clk); push({31'b0, syncReadyN}, 32'd1, "R8 single-cycle ready");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) step();
    @(negedge clk);
    push({31'b0, asyncReady}, 32'd1, "R10 asyncReady in reset");
    push({31'b0, syncReadyN}, 32'd1, "R10 syncReadyN in reset");
    step(); rstN = 1'b1;
    asyncRead(16'h030C, 4'h0, 0, 32'h0, "R10 bank and regs zero");
    asyncRead(16'h0304, 4'h0, 0, 32'h0, "R10 register zero");

    // R3 byte lanes; R2 address replaced with FFFF in every data phase
    asyncWrite(16'h0300, 4'h0, 32'h11223344);
    asyncRead(16'h0300, 4'h0, 0, 32'h11223344, "R3 full word write (R2 latch held)");
    asyncWrite(16'h0300, 4'b1101, 32'hAABBCCDD);
    asyncRead(16'h0300, 4'h0, 0, 32'h1122CC44, "R3 single byte lane");

    // R1 decode misses
    asyncWrite(16'h0400, 4'h0, 32'hDEADBEEF);
    asyncRead(16'h0300, 4'h0, 0, 32'h1122CC44, "R1 base mismatch ignored");
    addrEnN = 1'b1;
    asyncWrite(16'h0300, 4'h0, 32'h0);
    addrEnN = 1'b0;
    asyncRead(16'h0300, 4'h0, 0, 32'h1122CC44, "R1 address enable high ignored");
    asyncWrite(16'h040C, 4'h0, 32'h00050000);
    asyncRead(16'h030C, 4'h0, 0, 32'h0, "R1 miss leaves bank");

    // R4 / R5 bank select
    asyncWrite(16'h030C, 4'b1100, 32'h00005A5A);
    asyncRead(16'h030C, 4'h0, 0, 32'h00005A5A, "R5 half-word at 0xC");
    asyncWrite(16'h030C, 4'h0, 32'h0003FFFF);
    asyncRead(16'h030C, 4'h0, 0, 32'h00030000, "R4 dword 0xC sets bank only");
    asyncWrite(16'h0300, 4'h0, 32'h33333333);
    asyncRead(16'h0300, 4'h0, 0, 32'h33333333, "R5 bank 3 register");
    asyncWrite(16'h030E, 4'b0011, 32'h0);
    asyncRead(16'h030C, 4'h0, 0, 32'h00005A5A, "R4 low half kept in bank 0");
    asyncRead(16'h0300, 4'h0, 0, 32'h1122CC44, "R5 banks separate");

    // R6 16-bit host
    bus16 = 1'b1;
    asyncWrite(16'h0302, 4'b1100, 32'h0000BEEF);
    asyncWrite(16'h0300, 4'b1100, 32'h00001234);
    asyncRead(16'h0302, 4'b1100, 0, 32'h0000BEEF, "R6 A1 high upper half");
    asyncRead(16'h0300, 4'b1100, 0, 32'h00001234, "R6 A1 low lower half");
    bus16 = 1'b0;
    asyncRead(16'h0300, 4'h0, 0, 32'hBEEF1234, "R6 halves placed in word");

    // R8 clocked bus
    syncAccess(16'h0304, 4'h0, 1, 32'h55AA55AA, 1, 0, 32'h0, "");
    syncAccess(16'h0304, 4'h0, 0, 32'h0, 1, 1, 32'h55AA55AA, "R8 clocked read");
    syncAccess(16'h0404, 4'h0, 1, 32'h99999999, 0, 0, 32'h0, "");
    asyncRead(16'h0404 - 16'h0100, 4'h0, 0, 32'h55AA55AA, "R8 unselected clocked write ignored");

    // R9 packet port
    asyncWrite(16'h030C, 4'h0, 32'h00020000);
    addrEnN = 1'b1; dataCsN = 1'b0;
    for (int i = 0; i < 16; i++) begin
      expMem[i] = 32'h10000000 + i * 32'h01010101;
      if (i % 2 == 0) asyncWrite(16'hFFF0, 4'h0, expMem[i]);
      else syncAccess(16'hFFF0, 4'h0, 1, expMem[i], 1, 0, 32'h0, "");
    end
    addrEnN = 1'b0; dataCsN = 1'b1;
    for (int i = 0; i < 4; i++)
      asyncRead(16'h0308, 4'h0, 1, expMem[i], "R9 decoded port read");
    dataCsN = 1'b0;
    for (int i = 4; i < 10; i++)
      asyncRead(16'hFFF0, 4'h0, 1, expMem[i], "R9 chip-select async read");
    for (int i = 10; i < 16; i++)
      syncAccess(16'hFFF0, 4'h0, 0, 32'h0, 1, 1, expMem[i], "R9 chip-select clocked read");
    dataCsN = 1'b1;
    asyncRead(16'h0308, 4'h0, 1, expMem[0], "R9 pointer wraps");

    repeat (3) step();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule